// File: doc/BRIEF.md
# External Data Bus Stretch Controller

This block serves byte read and write requests from an 8-bit microcontroller core to the on-chip data memories that sit outside the core's own address space. A request arrives either with a full 16-bit pointer address or with an 8-bit register-indirect address. In the indirect case, the upper address byte comes from a page register held inside the block. The effective address is decoded into one of three physical regions: general data RAM, coprocessor data RAM, or configuration register RAM. Any other address is unmapped.

Each access lasts a whole number of clock cycles. That number is one, plus a software-set stretch value of 0 to 7, plus a fixed wait count for the region. For the whole access the block holds a one-hot region select, a read or write strobe, the in-region offset and the write data. In the final cycle it raises a one-cycle done pulse, and for reads it returns the data in that same cycle. The stretch value and the page byte are read and written through a small register port.

Top module: `xdata_stretch_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, sel_o, rd_o and wr_o are 0. The stretch field reads 1 and the page register reads 0x00, so the first access after reset uses a stretch of 1.
- R2: Decode sets sel_o bit 0 for 0x0000–0x07FF, bit 1 for 0x1000–0x11FF and bit 2 for 0x2000–0x20FF. At most one bit is set, and mem_addr_o carries the address minus the region base.
- R3: An access accepted at a clock edge keeps busy_o high for exactly 1 + stretch + wait cycles, with wait 0 for bits 0 and 2 and 6 for bit 1. done_o is high only in the last of those cycles. sel_o and mem_addr_o hold steady across the access.
- R4: rdata_o equals the selected region's byte lane of mem_rdata_i in the done cycle of a read (lane n is bits 8n+7:8n). At all other times rdata_o is 0x00.
- R5: A mapped read asserts rd_o for the whole access and a mapped write asserts wr_o. They are never both high. mem_wdata_o carries the request's write data, and the target commits it at the edge that ends the done cycle.
- R6: An unmapped address asserts no select, no rd_o and no wr_o. It changes no memory, reads back 0x00, and completes after 1 + stretch cycles.
- R7: With indirect_i high, the effective address is {page register, addr_i[7:0]}. With indirect_i low, it is addr_i.
- R8: A request is accepted only while busy_o is low. A request raised during an access is ignored and leaves no trace.
- R9: The stretch value is sampled when a request is accepted. A stretch write during an access takes effect from the next access.
- R10: With cfg_sel_i = 0 the register port reaches the stretch field: it writes cfg_wdata_i[2:0] and reads {5'b0, stretch}. With cfg_sel_i = 1 it reaches the 8-bit page register. Writes happen on edges where cfg_we_i is high.
- R11: A stretch of 7 gives the longest accesses: 14 cycles for the coprocessor region and 8 cycles for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, accepted when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| indirect_i | input | 1 | 1 = register-indirect form using the page register |
| addr_i | input | 16 | Pointer address (only bits 7:0 are used when indirect) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the done cycle |
| done_o | output | 1 | One-cycle pulse in the last access cycle |
| busy_o | output | 1 | Access in progress |
| cfg_we_i | input | 1 | Register port write enable |
| cfg_sel_i | input | 1 | 0 = stretch field, 1 = page register |
| cfg_wdata_i | input | 8 | Register port write data |
| cfg_rdata_o | output | 8 | Register port read data |
| sel_o | output | 3 | One-hot region select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| mem_addr_o | output | 11 | Offset within the selected region |
| mem_wdata_o | output | 8 | Write data to the region |
| mem_rdata_i | input | 24 | Region read data, one byte lane per region |

## Verification
The hardest case to reach from the ports is a stretch write or a second request landing in the middle of a running access. A later access must then show that the new stretch applies only from that point on and that the ignored request wrote nothing. The stimulus raises the register write or the stray request in a chosen cycle of a long coprocessor access. It then follows with accesses whose length and read-back data reveal any leak. Unmapped writes are aimed at addresses whose low bits alias mapped offsets, so that a spurious strobe would show up as corrupted data.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int SW     = 3;
  localparam int NREG   = 3;
  localparam int OFF_W  = 11;
  localparam int MAX_WAIT = 6;
  localparam logic [SW-1:0] STRETCH_RST = SW'(1);

  localparam logic [AW-1:0] REG_BASE  [NREG] = '{16'h0000, 16'h1000, 16'h2000};
  localparam int            REG_ABITS [NREG] = '{11, 9, 8};
  localparam int            REG_WAIT  [NREG] = '{0, MAX_WAIT, 0};

  localparam int LEN_MAX = 1 + (2**SW - 1) + MAX_WAIT;
  localparam int LEN_W   = $clog2(LEN_MAX + 1);
endpackage

// File: rtl/xs_addr_form.sv
module xs_addr_form
  import xs_pkg::*;
(
  input  logic          indirect_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] page_i,
  output logic [AW-1:0] eff_addr_o
);
  assign eff_addr_o = indirect_i ? {page_i, addr_i[DW-1:0]} : addr_i;
endmodule

// File: rtl/xs_decode.sv
module xs_decode
  import xs_pkg::*;
(
  input  logic [AW-1:0]    addr_i,
  output logic [NREG-1:0]  hit_o,
  output logic [OFF_W-1:0] off_o,
  output logic [LEN_W-1:0] wait_o
);
  always_comb begin
    hit_o  = '0;
    off_o  = '0;
    wait_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if ((addr_i >> REG_ABITS[i]) == (REG_BASE[i] >> REG_ABITS[i])) begin
        hit_o[i] = 1'b1;
        off_o    = addr_i[OFF_W-1:0] & OFF_W'((1 << REG_ABITS[i]) - 1);
        wait_o   = LEN_W'(REG_WAIT[i]);
      end
    end
  end
endmodule

// File: rtl/xs_timer.sv
module xs_timer
  import xs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i - LEN_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - LEN_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/xs_cfg_regs.sv
module xs_cfg_regs
  import xs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [SW-1:0] stretch_o,
  output logic [DW-1:0] page_o
);
  logic [SW-1:0] stretch_q;
  logic [DW-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stretch_q <= STRETCH_RST;
      page_q    <= '0;
    end else if (we_i) begin
      if (sel_i) page_q    <= wdata_i;
      else       stretch_q <= wdata_i[SW-1:0];
    end
  end

  assign rdata_o   = sel_i ? page_q : {{(DW-SW){1'b0}}, stretch_q};
  assign stretch_o = stretch_q;
  assign page_o    = page_q;
endmodule

// File: rtl/xdata_stretch_ctrl.sv
module xdata_stretch_ctrl
  import xs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               indirect_i,
  input  logic [15:0]        addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               done_o,
  output logic               busy_o,
  input  logic               cfg_we_i,
  input  logic               cfg_sel_i,
  input  logic [7:0]         cfg_wdata_i,
  output logic [7:0]         cfg_rdata_o,
  output logic [2:0]         sel_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic [10:0]        mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [23:0]        mem_rdata_i
);
  logic [SW-1:0]    stretch;
  logic [DW-1:0]    page;
  logic [AW-1:0]    eff_addr;
  logic [NREG-1:0]  hit;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] wait_cnt, len;
  logic             accept, busy, last;

  logic [NREG-1:0]  sel_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic [DW-1:0]    wdata_q;

  xs_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .stretch_o(stretch), .page_o(page)
  );

  xs_addr_form u_addr (
    .indirect_i, .addr_i, .page_i(page), .eff_addr_o(eff_addr)
  );

  xs_decode u_dec (
    .addr_i(eff_addr), .hit_o(hit), .off_o(off), .wait_o(wait_cnt)
  );

  assign accept = req_i && !busy;
  assign len    = LEN_W'(1) + LEN_W'(stretch) + wait_cnt;

  xs_timer u_tmr (
    .clk_i, .rst_ni, .start_i(accept), .len_i(len),
    .busy_o(busy), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      sel_q   <= hit;
      off_q   <= off;
      wr_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  // read return: AND-OR over region lanes
  logic [DW-1:0] lane [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_lane
    assign lane[g] = sel_q[g] ? mem_rdata_i[g*DW +: DW] : '0;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) rd_mux = rd_mux | lane[i];
  end

  logic mapped;
  assign mapped      = |sel_q;
  assign busy_o      = busy;
  assign done_o      = last;
  assign sel_o       = busy ? sel_q : '0;
  assign rd_o        = busy && mapped && !wr_q;
  assign wr_o        = busy && mapped && wr_q;
  assign mem_addr_o  = off_q;
  assign mem_wdata_o = wdata_q;
  assign rdata_o     = (last && !wr_q) ? rd_mux : '0;
endmodule

// File: rtl/xs_checker.sv
module xs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        cfg_sel_i,
  input logic [7:0]  cfg_rdata_o,
  input logic [7:0]  rdata_o,
  input logic        done_o,
  input logic        busy_o,
  input logic [2:0]  sel_o,
  input logic        rd_o,
  input logic        wr_o,
  input logic [10:0] mem_addr_o
);
  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_done_in_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_done_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o && $stable(sel_o) && $stable(mem_addr_o)));

  p_rdata_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (rdata_o == 8'h00));

  p_no_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  p_strobe_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> (sel_o != 3'b000));

  p_sel_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != 3'b000) |-> busy_o);

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);

  p_cfg_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_sel_i |-> (cfg_rdata_o[7:3] == 5'b0));
endmodule

bind xdata_stretch_ctrl xs_checker u_chk (.*);

// File: tb/xdata_stretch_ctrl_tb.sv
`timescale 1ns/1ps
module xdata_stretch_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, indirect_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        done_o, busy_o;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [2:0]  sel_o;
  logic        rd_o, wr_o;
  logic [10:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [23:0] mem_rdata_i;

  always #2 clk_i = ~clk_i;

  xdata_stretch_ctrl u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] m0 [2048], m1 [512], m2 [256];
  logic [7:0] r0 [2048], r1 [512], r2 [256];
  int stretch_m = 1;
  logic [7:0] page_m = 8'h00;

  initial begin
    for (int i = 0; i < 2048; i++) begin m0[i] = 8'(i * 7 + 3); r0[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 512; i++)  begin m1[i] = 8'(i * 5 + 1); r1[i] = 8'(i * 5 + 1); end
    for (int i = 0; i < 256; i++)  begin m2[i] = 8'(i ^ 8'hA5); r2[i] = 8'(i ^ 8'hA5); end
  end

  // memory arrays modelled outside the block
  assign mem_rdata_i = {m2[mem_addr_o[7:0]], m1[mem_addr_o[8:0]], m0[mem_addr_o]};
  always @(posedge clk_i) begin
    if (done_o && wr_o) begin
      if (sel_o[0]) m0[mem_addr_o]      <= mem_wdata_o;
      if (sel_o[1]) m1[mem_addr_o[8:0]] <= mem_wdata_o;
      if (sel_o[2]) m2[mem_addr_o[7:0]] <= mem_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit s, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = s; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (s) page_m = d; else stretch_m = int'(d[2:0]);
  endtask

  task automatic cfg_read(input bit s, input string req);
    int exp;
    @(negedge clk_i);
    cfg_sel_i = s;
    #1;
    exp = s ? int'(page_m) : stretch_m;
    chk(cfg_rdata_o == 8'(exp), req, "cfg readback", int'(cfg_rdata_o), exp);
  endtask

  task automatic access(input bit we, input bit ind, input logic [15:0] a, input logic [7:0] wd,
                        input string req, input int inj_k, input int cfg_k, input logic [2:0] cfg_val);
    logic [15:0] ea;
    int ri, off, wt, len, exp_rd;
    logic [2:0] esel;
    ea = ind ? {page_m, a[7:0]} : a;
    ri = -1; off = 0; wt = 0;
    if (ea <= 16'h07FF) begin ri = 0; off = int'(ea); end
    else if (ea >= 16'h1000 && ea <= 16'h11FF) begin ri = 1; off = int'(ea) - 'h1000; wt = 6; end
    else if (ea >= 16'h2000 && ea <= 16'h20FF) begin ri = 2; off = int'(ea) - 'h2000; end
    len  = 1 + stretch_m + wt;
    esel = (ri < 0) ? 3'b000 : 3'(1 << ri);
    case (ri)
      0: exp_rd = int'(r0[off]);
      1: exp_rd = int'(r1[off]);
      2: exp_rd = int'(r2[off]);
      default: exp_rd = 0;
    endcase
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; indirect_i = ind; addr_i = a; wdata_i = wd;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk_i);
      req_i = 1'b0; cfg_we_i = 1'b0;
      chk(busy_o == 1'b1, req, "busy in access", int'(busy_o), 1);
      chk(done_o == (k == len), req, "done timing", int'(done_o), int'(k == len));
      chk(sel_o == esel, req, "region select", int'(sel_o), int'(esel));
      chk(rd_o == (ri >= 0 && !we), req, "read strobe", int'(rd_o), int'(ri >= 0 && !we));
      chk(wr_o == (ri >= 0 && we), req, "write strobe", int'(wr_o), int'(ri >= 0 && we));
      if (ri >= 0) chk(int'(mem_addr_o) == off, req, "offset", int'(mem_addr_o), off);
      if (ri >= 0 && we) chk(mem_wdata_o == wd, req, "write data", int'(mem_wdata_o), int'(wd));
      if (k == len && !we) chk(int'(rdata_o) == exp_rd, req, "read data", int'(rdata_o), exp_rd);
      else chk(rdata_o == 8'h00, req, "rdata idle zero", int'(rdata_o), 0);
      if (k == inj_k) begin
        req_i = 1'b1; we_i = 1'b1; indirect_i = 1'b0; addr_i = 16'h0000; wdata_i = 8'hEE;
      end
      if (k == cfg_k) begin
        cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = {5'b0, cfg_val};
      end
    end
    if (cfg_k > 0) stretch_m = int'(cfg_val);
    if (we && ri == 0) r0[off] = wd;
    if (we && ri == 1) r1[off] = wd;
    if (we && ri == 2) r2[off] = wd;
    @(negedge clk_i);
    req_i = 1'b0; cfg_we_i = 1'b0;
    chk(busy_o == 1'b0, req, "idle after done", int'(busy_o), 0);
    chk(done_o == 1'b0, req, "done single pulse", int'(done_o), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk_i); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: actual=%0d cycles expected=completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && sel_o == 0 && rd_o == 0 && wr_o == 0, "R1", "outputs in reset",
        int'({busy_o, done_o, sel_o, rd_o, wr_o}), 0);
    cfg_sel_i = 1'b0; #1;
    chk(cfg_rdata_o == 8'h01, "R1", "stretch in reset", int'(cfg_rdata_o), 1);
    @(negedge clk_i); rst_ni = 1'b1;
    cfg_read(1'b0, "R1");
    cfg_read(1'b1, "R1");
    access(0, 0, 16'h0000, 8'h00, "R1", 0, 0, 3'd0);
    // R2 / R5 boundaries
    access(1, 0, 16'h07FF, 8'h5A, "R5", 0, 0, 3'd0);
    access(0, 0, 16'h07FF, 8'h00, "R2", 0, 0, 3'd0);
    access(1, 0, 16'h1000, 8'h3C, "R5", 0, 0, 3'd0);
    access(0, 0, 16'h1000, 8'h00, "R3", 0, 0, 3'd0);
    access(0, 0, 16'h11FF, 8'h00, "R2", 0, 0, 3'd0);
    access(1, 0, 16'h2000, 8'hC3, "R5", 0, 0, 3'd0);
    access(0, 0, 16'h2000, 8'h00, "R4", 0, 0, 3'd0);
    access(0, 0, 16'h20FF, 8'h00, "R2", 0, 0, 3'd0);
    // R6 unmapped, including aliases of mapped offsets
    access(1, 0, 16'h0800, 8'h99, "R6", 0, 0, 3'd0);
    access(1, 0, 16'h1200, 8'h98, "R6", 0, 0, 3'd0);
    access(1, 0, 16'h2100, 8'h97, "R6", 0, 0, 3'd0);
    access(0, 0, 16'h0FFF, 8'h00, "R6", 0, 0, 3'd0);
    access(0, 0, 16'hFFFF, 8'h00, "R6", 0, 0, 3'd0);
    access(0, 0, 16'h0000, 8'h00, "R6", 0, 0, 3'd0);
    access(0, 0, 16'h1000, 8'h00, "R6", 0, 0, 3'd0);
    access(0, 0, 16'h2000, 8'h00, "R6", 0, 0, 3'd0);
    // R3 stretch 0
    cfg_write(1'b0, 8'h00);
    access(0, 0, 16'h0010, 8'h00, "R3", 0, 0, 3'd0);
    access(0, 0, 16'h1010, 8'h00, "R3", 0, 0, 3'd0);
    access(0, 0, 16'h3000, 8'h00, "R3", 0, 0, 3'd0);
    // R10 / R11
    cfg_write(1'b0, 8'hFF);
    cfg_read(1'b0, "R10");
    access(0, 0, 16'h1123, 8'h00, "R11", 0, 0, 3'd0);
    access(1, 0, 16'h2042, 8'h11, "R11", 0, 0, 3'd0);
    access(0, 0, 16'h2042, 8'h00, "R11", 0, 0, 3'd0);
    access(0, 0, 16'h8000, 8'h00, "R11", 0, 0, 3'd0);
    // R7 indirect form
    cfg_write(1'b0, 8'h01);
    cfg_write(1'b1, 8'h10);
    cfg_read(1'b1, "R10");
    access(0, 1, 16'hAB05, 8'h00, "R7", 0, 0, 3'd0);
    access(1, 1, 16'h00F0, 8'h77, "R7", 0, 0, 3'd0);
    access(0, 0, 16'h10F0, 8'h00, "R7", 0, 0, 3'd0);
    access(0, 0, 16'h0003, 8'h00, "R7", 0, 0, 3'd0);
    cfg_write(1'b1, 8'h20);
    access(0, 1, 16'h5581, 8'h00, "R7", 0, 0, 3'd0);
    cfg_write(1'b1, 8'h08);
    access(1, 1, 16'h0000, 8'h66, "R7", 0, 0, 3'd0);
    cfg_write(1'b1, 8'h00);
    access(0, 1, 16'h1207, 8'h00, "R7", 0, 0, 3'd0);
    access(0, 0, 16'h0000, 8'h00, "R7", 0, 0, 3'd0);
    // R8 request during access
    access(0, 0, 16'h1001, 8'h00, "R8", 2, 0, 3'd0);
    access(0, 0, 16'h1001, 8'h00, "R8", 7, 0, 3'd0);
    access(0, 0, 16'h0000, 8'h00, "R8", 0, 0, 3'd0);
    // R9 stretch write mid-access
    cfg_write(1'b0, 8'h02);
    access(0, 0, 16'h1002, 8'h00, "R9", 0, 3, 3'd5);
    access(0, 0, 16'h1003, 8'h00, "R9", 0, 0, 3'd0);
    access(0, 0, 16'h0004, 8'h00, "R9", 0, 1, 3'd0);
    access(0, 0, 16'h0005, 8'h00, "R9", 0, 0, 3'd0);
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule